// File: doc/BRIEF.md
# Phase-Chained Two-Channel PWM Generator

This block drives the switches of a resonant converter with two PWM channels, a leader and a follower. Each channel has an up-counting period timer and two outputs, a high-side drive and a low-side drive. The high side is on while the channel count lies in a window set by a phase compare and a duty compare. The low side has its own on and off compares, so its timing does not depend on the high side. Software commonly places the low-side turn-off at the period and the low-side turn-on at half the period plus a low-side dead time.

Both channels share one master period. The leader uses the master phase and duty values, and the follower uses private phase and duty values. The leader runs freely. The follower restarts its cycle whenever the leader count matches one of two leader event compares, chosen by `fol_src`, and this gives the follower a phase offset from the leader. All timing values can be written while the block runs. A write goes into a shadow set. Each channel copies the whole shadow set into its working values at the start of its own cycle, so a frequency change updates the period and the phase offset together.

Top module: `pwm_chain_pair`

## Requirements
- R1: While reset is asserted, and after it is released with `en` low, all four outputs are low.
- R2: A running channel counts 0, 1, …, P−1 and then returns to 0, where P is its working period. A period of 0 or 1 holds the count at 0.
- R3: `lead_hs` is high in the leader counts c with phase ≤ c < duty, using the master phase and duty. `fol_hs` does the same in the follower counts, using the follower's private phase and duty.
- R4: Each low-side output is high in the counts c of its channel with on ≤ c < off. When off ≥ P, the output stays high to the end of the cycle.
- R5: When duty ≤ phase, or phase ≥ P, the high side stays low for the whole cycle.
- R6: A write with `wr` high stores all inputs into the shadow set. The working values of a channel change only at that channel's cycle start, and they all take the shadow values of that moment together.
- R7: After enable, the follower holds its count at 0 with both of its outputs low until the first leader event.
- R8: A leader event is the leader count equal to its event-C compare (`fol_src`=0) or its event-D compare (`fol_src`=1). The follower is at count 0 in the clock cycle after the event, so it lags the leader by the compare value plus one. `fol_src` is sampled on every clock.
- R9: When `en` is sampled low, all outputs go low and both counters return to 0. The first clock that samples `en` high starts a leader cycle at count 0 with fresh working values.
- R10: The follower also wraps by itself at its own working period. It picks up a new master period at its own next cycle start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Run enable for both channels |
| wr | input | 1 | Capture all value inputs into the shadow set |
| fol_src | input | 1 | Follower start source: 0 selects event C, 1 selects event D |
| period | input | W | Master period |
| lead_ph | input | W | Master phase (leader high-side on) |
| lead_dc | input | W | Master duty (leader high-side off) |
| fol_ph | input | W | Follower private phase |
| fol_dc | input | W | Follower private duty |
| lead_lon | input | W | Leader low-side on compare |
| lead_loff | input | W | Leader low-side off compare |
| fol_lon | input | W | Follower low-side on compare |
| fol_loff | input | W | Follower low-side off compare |
| lead_evc | input | W | Leader event-C compare |
| lead_evd | input | W | Leader event-D compare |
| lead_hs | output | 1 | Leader high-side drive |
| lead_ls | output | 1 | Leader low-side drive |
| fol_hs | output | 1 | Follower high-side drive |
| fol_ls | output | 1 | Follower low-side drive |

## Verification
The assertions check, on every cycle, that the leader count stays below its period, that the working values hold between cycle starts, that an unstarted follower stays at 0 with quiet outputs, that a leader event restarts the follower, and that disabling silences all outputs. Only the bench scenarios can show the exact output waveforms: the windows for several compare sets, the lag set by the C or D selection, a mid-cycle write that changes the period, and the cases where a compare lies beyond the period or duty does not exceed phase.

// File: rtl/pwm_chain_pair.sv
module pwm_chain_pair #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         wr,
  input  logic         fol_src,
  input  logic [W-1:0] period,
  input  logic [W-1:0] lead_ph,
  input  logic [W-1:0] lead_dc,
  input  logic [W-1:0] fol_ph,
  input  logic [W-1:0] fol_dc,
  input  logic [W-1:0] lead_lon,
  input  logic [W-1:0] lead_loff,
  input  logic [W-1:0] fol_lon,
  input  logic [W-1:0] fol_loff,
  input  logic [W-1:0] lead_evc,
  input  logic [W-1:0] lead_evd,
  output logic         lead_hs,
  output logic         lead_ls,
  output logic         fol_hs,
  output logic         fol_ls
);
  localparam int WX = W + 1;

  logic [W-1:0] s_per, s_lph, s_ldc, s_fph, s_fdc, s_lon0, s_loff0, s_lon1, s_loff1, s_evc, s_evd;
  logic [W-1:0] p0, ph0, dc0, on0, off0, evc, evd;
  logic [W-1:0] p1, ph1, dc1, on1, off1;
  logic [W-1:0] cnt0, cnt1;
  logic         run0, run1;
  logic         wrap0, wrap1, st0, st1, ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_per <= '0; s_lph <= '0; s_ldc <= '0; s_fph <= '0; s_fdc <= '0;
      s_lon0 <= '0; s_loff0 <= '0; s_lon1 <= '0; s_loff1 <= '0;
      s_evc <= '0; s_evd <= '0;
    end else if (wr) begin
      s_per <= period; s_lph <= lead_ph; s_ldc <= lead_dc;
      s_fph <= fol_ph; s_fdc <= fol_dc;
      s_lon0 <= lead_lon; s_loff0 <= lead_loff;
      s_lon1 <= fol_lon; s_loff1 <= fol_loff;
      s_evc <= lead_evc; s_evd <= lead_evd;
    end
  end

  assign wrap0 = (WX'(cnt0) + WX'(1)) >= WX'(p0);
  assign wrap1 = (WX'(cnt1) + WX'(1)) >= WX'(p1);
  assign st0   = en && (!run0 || wrap0);
  assign ev    = en && run0 && (cnt0 == (fol_src ? evd : evc));
  assign st1   = ev || (en && run1 && wrap1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt0 <= '0; run0 <= 1'b0;
      p0 <= '0; ph0 <= '0; dc0 <= '0; on0 <= '0; off0 <= '0; evc <= '0; evd <= '0;
    end else if (!en) begin
      cnt0 <= '0; run0 <= 1'b0;
    end else if (st0) begin
      cnt0 <= '0; run0 <= 1'b1;
      p0 <= s_per; ph0 <= s_lph; dc0 <= s_ldc;
      on0 <= s_lon0; off0 <= s_loff0; evc <= s_evc; evd <= s_evd;
    end else begin
      cnt0 <= cnt0 + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt1 <= '0; run1 <= 1'b0;
      p1 <= '0; ph1 <= '0; dc1 <= '0; on1 <= '0; off1 <= '0;
    end else if (!en) begin
      cnt1 <= '0; run1 <= 1'b0;
    end else if (st1) begin
      cnt1 <= '0; run1 <= 1'b1;
      p1 <= s_per; ph1 <= s_fph; dc1 <= s_fdc;
      on1 <= s_lon1; off1 <= s_loff1;
    end else if (run1) begin
      cnt1 <= cnt1 + 1'b1;
    end
  end

  assign lead_hs = run0 && (cnt0 >= ph0) && (cnt0 < dc0);
  assign lead_ls = run0 && (cnt0 >= on0) && (cnt0 < off0);
  assign fol_hs  = run1 && (cnt1 >= ph1) && (cnt1 < dc1);
  assign fol_ls  = run1 && (cnt1 >= on1) && (cnt1 < off1);

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run0 && p0 > 1) |-> (cnt0 < p0));

  // R6
  active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run0 && !st0) |=> ($stable(p0) && $stable(ph0) && $stable(dc0) && $stable(evc) && $stable(evd)));

  // R7
  fol_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run1 |-> (cnt1 == '0 && !fol_hs && !fol_ls));

  // R8
  fol_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && run0 && cnt0 == (fol_src ? evd : evc)) |=> (run1 && cnt1 == '0));

  // R9
  dis_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!lead_hs && !lead_ls && !fol_hs && !fol_ls));
endmodule

// File: tb/pwm_chain_pair_tb_top.sv
module pwm_chain_pair_tb_top;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, wr = 1'b0, fol_src = 1'b0;
  logic [W-1:0] period = '0, lead_ph = '0, lead_dc = '0, fol_ph = '0, fol_dc = '0;
  logic [W-1:0] lead_lon = '0, lead_loff = '0, fol_lon = '0, fol_loff = '0, lead_evc = '0, lead_evd = '0;
  logic lead_hs, lead_ls, fol_hs, fol_ls;

  int total = 0, bad = 0;
  bit finished = 0;

  int m_run0, m_c0, m_run1, m_c1;
  int a_p0, a_ph0, a_dc0, a_on0, a_off0, a_evc, a_evd;
  int a_p1, a_ph1, a_dc1, a_on1, a_off1;
  int s_p, s_lph, s_ldc, s_fph, s_fdc, s_on0, s_off0, s_on1, s_off1, s_evc, s_evd;

  always #4 clk = ~clk;

  pwm_chain_pair #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .wr(wr), .fol_src(fol_src),
    .period(period), .lead_ph(lead_ph), .lead_dc(lead_dc), .fol_ph(fol_ph), .fol_dc(fol_dc),
    .lead_lon(lead_lon), .lead_loff(lead_loff), .fol_lon(fol_lon), .fol_loff(fol_loff),
    .lead_evc(lead_evc), .lead_evd(lead_evd),
    .lead_hs(lead_hs), .lead_ls(lead_ls), .fol_hs(fol_hs), .fol_ls(fol_ls));

  task automatic chk(string tag, string what, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s at %0t: actual=%0b expected=%0b", tag, what, $time, act, exp);
    end
  endtask

  function automatic logic win(int run, int c, int lo, int hi);
    return (run != 0) && (c >= lo) && (c < hi);
  endfunction

  task automatic model_edge();
    int st0, st1, ev, wr0, wr1;
    if (!en) begin
      m_run0 = 0; m_c0 = 0; m_run1 = 0; m_c1 = 0;
    end else begin
      wr0 = (m_c0 + 1 >= a_p0);
      wr1 = (m_c1 + 1 >= a_p1);
      st0 = (m_run0 == 0) || wr0;
      ev  = (m_run0 != 0) && (m_c0 == (fol_src ? a_evd : a_evc));
      st1 = ev || ((m_run1 != 0) && wr1);
      if (st0) begin
        m_c0 = 0; m_run0 = 1;
        a_p0 = s_p; a_ph0 = s_lph; a_dc0 = s_ldc; a_on0 = s_on0; a_off0 = s_off0;
        a_evc = s_evc; a_evd = s_evd;
      end else m_c0++;
      if (st1) begin
        m_c1 = 0; m_run1 = 1;
        a_p1 = s_p; a_ph1 = s_fph; a_dc1 = s_fdc; a_on1 = s_on1; a_off1 = s_off1;
      end else if (m_run1 != 0) m_c1++;
    end
    if (wr) begin
      s_p = period; s_lph = lead_ph; s_ldc = lead_dc; s_fph = fol_ph; s_fdc = fol_dc;
      s_on0 = lead_lon; s_off0 = lead_loff; s_on1 = fol_lon; s_off1 = fol_loff;
      s_evc = lead_evc; s_evd = lead_evd;
    end
  endtask

  task automatic run(int n, string tag);
    for (int i = 0; i < n; i++) begin
      chk(tag, "lead_hs", lead_hs, win(m_run0, m_c0, a_ph0, a_dc0));
      chk(tag, "lead_ls", lead_ls, win(m_run0, m_c0, a_on0, a_off0));
      chk(tag, "fol_hs", fol_hs, win(m_run1, m_c1, a_ph1, a_dc1));
      chk(tag, "fol_ls", fol_ls, win(m_run1, m_c1, a_on1, a_off1));
      model_edge();
      @(negedge clk);
    end
  endtask

  task automatic write(int p, int lph, int ldc, int fph, int fdc, int dtl, int evc_v, int evd_v, string tag);
    period = W'(p); lead_ph = W'(lph); lead_dc = W'(ldc); fol_ph = W'(fph); fol_dc = W'(fdc);
    lead_lon = W'(p / 2 + dtl); lead_loff = W'(p); fol_lon = W'(p / 2 + dtl); fol_loff = W'(p);
    lead_evc = W'(evc_v); lead_evd = W'(evd_v);
    wr = 1'b1;
    run(1, tag);
    wr = 1'b0;
  endtask

  task automatic t_reset();
    m_run0 = 0; m_c0 = 0; m_run1 = 0; m_c1 = 0;
    a_p0 = 0; a_ph0 = 0; a_dc0 = 0; a_on0 = 0; a_off0 = 0; a_evc = 0; a_evd = 0;
    a_p1 = 0; a_ph1 = 0; a_dc1 = 0; a_on1 = 0; a_off1 = 0;
    s_p = 0; s_lph = 0; s_ldc = 0; s_fph = 0; s_fdc = 0; s_on0 = 0; s_off0 = 0;
    s_on1 = 0; s_off1 = 0; s_evc = 0; s_evd = 0;
    repeat (3) @(negedge clk);
    chk("R1", "lead_hs", lead_hs, 1'b0);
    chk("R1", "fol_ls", fol_ls, 1'b0);
    rst_n = 1'b1;
    run(4, "R1");
  endtask

  task automatic t_base();
    int rise0, rise1, prev;
    write(20, 3, 9, 5, 15, 2, 7, 13, "R9");
    run(6, "R9");
    en = 1'b1;
    run(1, "R9");
    // first sample with en taken: leader at count 0, follower idle
    chk("R7", "fol_hs idle", fol_hs, 1'b0);
    rise0 = -1; rise1 = -1; prev = 0;
    for (int i = 0; i < 60; i++) begin
      if (lead_hs && !prev) begin
        if (rise0 < 0) rise0 = i; else if (rise1 < 0) rise1 = i;
      end
      prev = lead_hs;
      run(1, "R3");
    end
    total++;
    if (rise1 - rise0 != 20) begin
      bad++;
      $display("FAIL R2 period spacing actual=%0d expected=20", rise1 - rise0);
    end
    run(40, "R4");
  endtask

  task automatic t_short();
    en = 1'b0; run(2, "R9");
    write(1, 0, 1, 0, 5, 0, 0, 0, "R2");
    en = 1'b1; run(12, "R2");
  endtask

  task automatic t_no_pulse();
    en = 1'b0; run(2, "R9");
    write(16, 9, 9, 12, 4, 1, 3, 5, "R5");
    en = 1'b1; run(40, "R5");
    write(16, 20, 30, 16, 40, 1, 3, 5, "R5");
    run(40, "R5");
  endtask

  task automatic t_fol_wait();
    en = 1'b0; run(2, "R9");
    write(20, 0, 10, 0, 10, 2, 30, 25, "R7");
    en = 1'b1; run(45, "R7");
    chk("R7", "fol_hs never started", fol_hs, 1'b0);
  endtask

  task automatic t_sel();
    en = 1'b0; run(2, "R9");
    write(20, 2, 8, 1, 6, 3, 4, 11, "R8");
    fol_src = 1'b1;
    en = 1'b1; run(50, "R8");
    fol_src = 1'b0;
    run(50, "R8");
  endtask

  task automatic t_shadow();
    run(7, "R6");
    write(12, 1, 4, 2, 9, 1, 3, 6, "R6");
    run(30, "R6");
    write(26, 5, 15, 3, 20, 2, 9, 18, "R10");
    run(80, "R10");
  endtask

  task automatic t_disable_mid();
    run(5, "R9");
    en = 1'b0; run(6, "R9");
    en = 1'b1; run(40, "R9");
  endtask

  initial begin
    #(200000 * 8);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_base();
    t_short();
    t_no_pulse();
    t_fol_wait();
    t_sel();
    t_shadow();
    t_disable_mid();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule